// File: doc/BRIEF.md
# Serial Line Transmitter with Word Queue and Event Outputs

The block converts parallel words into an asynchronous serial line stream. Words enter through a simple valid-strobed write port into an internal first-in first-out queue. A shifter takes words from the queue and sends each one as a frame. The frame format is selected at run time: 5 to 8 data bits, an optional parity bit (odd or even), and one or two stop bits. Bit timing comes from an external baud tick. Each bit lasts 16 ticks, or 8 ticks when the 8x oversampling mode is selected.

Two status outputs support flow control by the producer. `wr_ready_o` shows that the queue has room for another word. `busy_o` shows that a frame is on the line. Four event outputs can each be enabled separately:
- queue fill level at or above a programmable trigger;
- a write that was lost because the queue was full;
- full drain, meaning the queue is empty and the shifter is idle;
- any change on the clear-to-send input.

A queue-clear strobe and a transmit enable give coarse control. The clear-to-send input only raises events. It never stalls the line.

Top module: `sertx_top`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits, which are high.
- R2: `cfg_len_i` selects the number of data bits as 5 + its value (0 gives 5, 3 gives 8). Data bits above that number are not sent.
- R3: With `cfg_par_en_i` high, a parity bit follows the data bits. With `cfg_par_even_i` high, the parity bit makes the count of ones in the data bits plus the parity bit even. With it low, that count is odd.
- R4: `cfg_two_stop_i` high sends two stop bits. Low sends one stop bit.
- R5: Each bit lasts 16 baud ticks, or 8 ticks while `cfg_os8_i` is high. The format is captured when a word is taken from the queue.
- R6: While `tx_en_i` is low, no new frame starts. Queued words are kept and are sent after `tx_en_i` rises.
- R7: `wr_ready_o` is high exactly while the queue holds fewer than DEPTH words (16 by default). `busy_o` is high from the start bit to the end of the last stop bit.
- R8: `irq_o[0]` (fill level) is high while the queue count is greater than or equal to `trig_i`.
- R9: `irq_o[1]` (overflow) is set when a write arrives while the queue is full. It stays set until `fifo_clr_i` clears it. The lost word is never sent.
- R10: `irq_o[2]` (drained) is high only while the queue is empty and `busy_o` is low.
- R11: `irq_o[3]` (clear-to-send change) pulses for one cycle for every edge on `cts_i`, two clock cycles after the edge (two-stage synchronizer).
- R12: Each `irq_o[k]` is forced low while `irq_en_i[k]` is low.
- R13: `fifo_clr_i` empties the queue and clears the overflow flag. A write in the same cycle is dropped. A frame already on the line completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud tick strobe, one cycle wide |
| tx_en_i | input | 1 | Allow new frames to start |
| fifo_clr_i | input | 1 | Empty the queue, clear overflow |
| wr_valid_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Word to queue |
| cfg_len_i | input | 2 | Data bits minus 5 |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_even_i | input | 1 | Even parity when high, odd when low |
| cfg_two_stop_i | input | 1 | Two stop bits |
| cfg_os8_i | input | 1 | 8 ticks per bit instead of 16 |
| trig_i | input | 5 | Fill-level trigger |
| irq_en_i | input | 4 | Per-event enables |
| cts_i | input | 1 | Clear-to-send input, monitored only |
| txd_o | output | 1 | Serial line |
| wr_ready_o | output | 1 | Queue can accept a word |
| busy_o | output | 1 | Frame in progress |
| irq_o | output | 4 | Events: level, overflow, drained, cts change |

## Verification
A corrupted bit counter or tick counter in the shifter shows up on `txd_o` within the same frame. The stop bits land in the wrong place or the wrong number of data bits appears, so the line decoder in the bench flags it at the end of that frame. A wrong queue count shows up at once on `wr_ready_o` and on the level and drained events. A dropped or duplicated word shows up as a scoreboard mismatch on the next frame, or as a nonempty queue at the end of the run. A stale synchronizer state produces a missing or extra event pulse within two cycles of a clear-to-send edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int FRAME_W = 12;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
    logic       os8;
  } frame_cfg_t;

  function automatic logic [FRAME_W-1:0] pack_frame(input logic [7:0] d, input frame_cfg_t c);
    logic [FRAME_W-1:0] f;
    logic p;
    int wl;
    f  = '1;
    p  = 1'b0;
    wl = 5 + int'(c.len);
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < wl) begin
        f[1+i] = d[i];
        p      = p ^ d[i];
      end
    end
    if (c.par_en) f[1+wl] = c.par_even ? p : ~p;
    return f;
  endfunction

  function automatic logic [3:0] frame_bits(input frame_cfg_t c);
    return 4'd7 + {2'b00, c.len} + {3'b000, c.par_en} + {3'b000, c.two_stop};
  endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == FULL);
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign dout_o  = mem[rd_ptr];
  assign count_o = cnt;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       tx_en_i,
  input  logic       hold_i,
  input  frame_cfg_t cfg_i,
  input  logic       empty_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       busy_o,
  output logic       txd_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [3:0]         left_q;
  logic [3:0]         tcnt_q;
  logic               os8_q;
  logic               busy_q;
  logic               load;
  logic               bit_end;

  assign load    = !busy_q && tx_en_i && !empty_i && !hold_i;
  assign bit_end = tick_i && (tcnt_q == (os8_q ? 4'd7 : 4'd15));
  assign pop_o   = load;
  assign busy_o  = busy_q;
  assign txd_o   = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      tcnt_q <= '0;
      os8_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= pack_frame(data_i, cfg_i);
      left_q <= frame_bits(cfg_i);
      tcnt_q <= '0;
      os8_q  <= cfg_i.os8;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (bit_end) begin
        tcnt_q <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sertx_events.sv
module sertx_events #(
  parameter int CW     = 5,
  parameter int N_SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] trig_i,
  input  logic          busy_i,
  input  logic          ovf_set_i,
  input  logic          clr_i,
  input  logic          cts_i,
  input  logic [3:0]    irq_en_i,
  output logic [3:0]    irq_o
);
  logic [N_SYNC-1:0] sync_q;
  logic              cts_prev_q;
  logic              ovf_q;
  logic [3:0]        raw;

  // Synchronizer resets to the deasserted (high) level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '1;
      cts_prev_q <= 1'b1;
    end else begin
      sync_q     <= {sync_q[N_SYNC-2:0], cts_i};
      cts_prev_q <= sync_q[N_SYNC-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (clr_i)     ovf_q <= 1'b0;
    else if (ovf_set_i) ovf_q <= 1'b1;
  end

  assign raw[0] = (count_i >= trig_i);
  assign raw[1] = ovf_q;
  assign raw[2] = (count_i == '0) && !busy_i;
  assign raw[3] = sync_q[N_SYNC-1] ^ cts_prev_q;

  for (genvar k = 0; k < 4; k++) begin : g_gate
    assign irq_o[k] = raw[k] & irq_en_i[k];
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          tx_en_i,
  input  logic          fifo_clr_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic [1:0]    cfg_len_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_even_i,
  input  logic          cfg_two_stop_i,
  input  logic          cfg_os8_i,
  input  logic [CW-1:0] trig_i,
  input  logic [3:0]    irq_en_i,
  input  logic          cts_i,
  output logic          txd_o,
  output logic          wr_ready_o,
  output logic          busy_o,
  output logic [3:0]    irq_o
);
  frame_cfg_t    cfg;
  logic [7:0]    fifo_dout;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_full, fifo_empty, pop;
  logic          ovf_set;

  assign cfg = '{len: cfg_len_i, par_en: cfg_par_en_i, par_even: cfg_par_even_i,
                 two_stop: cfg_two_stop_i, os8: cfg_os8_i};
  assign wr_ready_o = !fifo_full;
  assign ovf_set    = wr_valid_i && fifo_full && !fifo_clr_i;

  sertx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(fifo_clr_i),
    .push_i(wr_valid_i), .din_i(wr_data_i), .pop_i(pop),
    .dout_o(fifo_dout), .count_o(fifo_cnt), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  sertx_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .tx_en_i(tx_en_i),
    .hold_i(fifo_clr_i), .cfg_i(cfg), .empty_i(fifo_empty), .data_i(fifo_dout),
    .pop_o(pop), .busy_o(busy_o), .txd_o(txd_o)
  );

  sertx_events #(.CW(CW), .N_SYNC(2)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(fifo_cnt), .trig_i(trig_i),
    .busy_i(busy_o), .ovf_set_i(ovf_set), .clr_i(fifo_clr_i), .cts_i(cts_i),
    .irq_en_i(irq_en_i), .irq_o(irq_o)
  );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en_i,
  input logic          fifo_clr_i,
  input logic          wr_valid_i,
  input logic [3:0]    irq_en_i,
  input logic [CW-1:0] trig_i,
  input logic          txd_o,
  input logic          wr_ready_o,
  input logic          busy_o,
  input logic [3:0]    irq_o,
  input logic [CW-1:0] fifo_cnt
);
  p_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);

  p_no_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !busy_o) |=> !busy_o);

  p_full_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CW'(DEPTH)) |-> !wr_ready_o);

  p_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> (fifo_cnt >= trig_i));

  p_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ready_o && !fifo_clr_i) |=> (irq_o[1] || !irq_en_i[1]));

  p_drained_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[2] |-> (!busy_o && fifo_cnt == '0));

  p_clear_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (fifo_cnt == '0 && !irq_o[1]));
endmodule

bind sertx_top sertx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .fifo_clr_i(fifo_clr_i),
  .wr_valid_i(wr_valid_i), .irq_en_i(irq_en_i), .trig_i(trig_i), .txd_o(txd_o),
  .wr_ready_o(wr_ready_o), .busy_o(busy_o), .irq_o(irq_o), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tx_en = 1'b0, fifo_clr = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0, os8 = 1'b0;
  logic [CW-1:0] trig = CW'(8);
  logic [3:0] irq_en = 4'hF;
  logic cts = 1'b1;
  logic txd, wr_ready, busy;
  logic [3:0] irq;

  int checks = 0, errors = 0, frames = 0, expected_frames = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  sertx_top #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tx_en_i(tx_en), .fifo_clr_i(fifo_clr),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .cfg_len_i(cfg_len),
    .cfg_par_en_i(par_en), .cfg_par_even_i(par_even), .cfg_two_stop_i(two_stop),
    .cfg_os8_i(os8), .trig_i(trig), .irq_en_i(irq_en), .cts_i(cts),
    .txd_o(txd), .wr_ready_o(wr_ready), .busy_o(busy), .irq_o(irq)
  );

  // Baud tick every second clock
  initial forever begin
    @(negedge clk); tick = ~tick;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input bit expect_sent);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    if (expect_sent) begin exp_q.push_back(d); expected_frames++; end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || busy || !irq[2]) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: decodes the line and compares against the scoreboard
  initial begin
    logic prev;
    logic [11:0] rx;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        int bc, wl, nb;
        logic [7:0] d, e;
        logic p;
        bc = (os8 ? 8 : 16) * 2;
        wl = 5 + int'(cfg_len);
        nb = 1 + wl + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
        rx = '1;
        repeat (bc/2 - 1) @(negedge clk);
        rx[0] = txd;
        for (int i = 1; i < nb; i++) begin
          repeat (bc) @(negedge clk);
          rx[i] = txd;
        end
        frames++;
        chk("R1 start bit", {31'b0, rx[0]}, 32'd0);
        d = '0;
        for (int i = 0; i < 8; i++) if (i < wl) d[i] = rx[1+i];
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected frame act=%0h exp=none", d);
        end else begin
          e = exp_q.pop_front();
          e = e & 8'((1 << wl) - 1);
          chk("R1 R2 R5 frame data", {24'b0, d}, {24'b0, e});
          if (par_en) begin
            p = ^e;
            chk("R3 parity", {31'b0, rx[1+wl]}, {31'b0, (par_even ? p : ~p)});
          end
          chk("R4 stop bit", {31'b0, rx[nb-1]}, 32'd1);
          if (two_stop) chk("R4 first stop", {31'b0, rx[nb-2]}, 32'd1);
        end
        prev = 1'b1;
      end else begin
        prev = txd;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle high", {31'b0, txd}, 32'd1);
    chk("R7 ready at reset", {31'b0, wr_ready}, 32'd1);
    chk("R7 not busy at reset", {31'b0, busy}, 32'd0);
    chk("R10 drained at reset", {28'b0, irq}, 32'h4);

    // 8N1 16x
    tx_en = 1'b1;
    wr(8'hA5, 1); wr(8'h3C, 1); wr(8'h01, 1);
    drain();

    // R10: drained waits for the shifter
    wr(8'h5A, 1);
    repeat (2) @(negedge clk);
    chk("R7 busy in frame", {31'b0, busy}, 32'd1);
    chk("R10 not drained while busy", {31'b0, irq[2]}, 32'd0);
    drain();
    chk("R10 drained after frame", {31'b0, irq[2]}, 32'd1);

    // 7 bits even parity two stops 8x
    cfg_len = 2'd2; par_en = 1'b1; par_even = 1'b1; two_stop = 1'b1; os8 = 1'b1;
    wr(8'hFF, 1); wr(8'h13, 1); wr(8'h40, 1);
    drain();
    // 5 bits odd parity one stop
    cfg_len = 2'd0; par_even = 1'b0; two_stop = 1'b0;
    wr(8'hE7, 1); wr(8'h10, 1);
    drain();
    // 6 bits no parity 16x
    cfg_len = 2'd1; par_en = 1'b0; os8 = 1'b0;
    wr(8'h2A, 1); wr(8'hD5, 1);
    drain();
    cfg_len = 2'd3;

    // R6, R8, R7, R9: hold, level, fill, overflow
    tx_en = 1'b0; trig = CW'(3);
    wr(8'h11, 1); wr(8'h22, 1);
    chk("R8 below trigger", {31'b0, irq[0]}, 32'd0);
    wr(8'h33, 1);
    chk("R8 at trigger", {31'b0, irq[0]}, 32'd1);
    for (int i = 3; i < DEPTH; i++) wr(8'(i * 7 + 1), 1);
    repeat (40) @(negedge clk);
    chk("R6 held while disabled", {30'b0, busy, txd}, 32'd1);
    chk("R7 ready low when full", {31'b0, wr_ready}, 32'd0);
    chk("R9 no overflow yet", {31'b0, irq[1]}, 32'd0);
    wr(8'hEE, 0);
    chk("R9 overflow flagged", {31'b0, irq[1]}, 32'd1);
    irq_en = 4'b0000;
    @(negedge clk);
    chk("R12 all gated", {28'b0, irq}, 32'd0);
    irq_en = 4'hF;
    tx_en = 1'b1;
    drain();
    chk("R9 overflow sticky", {31'b0, irq[1]}, 32'd1);
    @(negedge clk); fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    chk("R13 clear drops overflow", {31'b0, irq[1]}, 32'd0);

    // R13: clear with words queued, and during a frame
    tx_en = 1'b0; trig = CW'(1);
    wr(8'h77, 0); wr(8'h78, 0); wr(8'h79, 0);
    chk("R8 level with words", {31'b0, irq[0]}, 32'd1);
    fifo_clr = 1'b1; wr_valid = 1'b1; wr_data = 8'h99;
    @(negedge clk); fifo_clr = 1'b0; wr_valid = 1'b0;
    chk("R13 queue empty after clear", {30'b0, irq[2], irq[0]}, 32'h2);
    tx_en = 1'b1;
    wr(8'h6B, 1); wr(8'h6C, 0);
    repeat (3) @(negedge clk);
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    chk("R13 frame continues", {31'b0, busy}, 32'd1);
    drain();
    trig = CW'(8);

    // R11: clear-to-send edges
    pulses = 0;
    @(negedge clk); cts = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq[3]) pulses++;
      if (i == 1) chk("R11 pulse two cycles after edge", {31'b0, irq[3]}, 32'd1);
    end
    cts = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (irq[3]) pulses++; end
    chk("R11 one pulse per edge", pulses, 32'd2);
    irq_en = 4'b0111; pulses = 0;
    cts = 1'b0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (irq[3]) pulses++; end
    chk("R12 cts event gated", pulses, 32'd0);
    irq_en = 4'hF;

    repeat (20) @(negedge clk);
    chk("R9 all words sent once", frames, expected_frames);
    chk("R1 scoreboard empty", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule